// File: doc/BRIEF.md
# Edge-Sensing GPIO Controller

This block is a bank of general-purpose pins with a small register file. Software uses it to choose, for each pin, whether the pin drives or only listens. Driven pins can be push-pull or can only pull low. Every pin watches its own level for transitions and latches a sticky event flag when one arrives. Unmasked flags combine into a single interrupt line, and an encoded index names the pending pin that has the highest priority.

The register port is a plain synchronous bus. A write commits on the rising clock edge when the write strobe is high. Read data is a combinational function of the address. All pin-wide vectors, both in registers and at the pin ports, put pin n at bit position NPINS-1-n, so pin 0 is the most significant bit. Pin inputs are asynchronous and pass through a synchronizer before any logic uses them.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero, no pin drives (pin_oe all zero), irq is low and irq_pin is zero.
- R2: Pin n occupies bit NPINS-1-n of every register and of pin_in, pin_out and pin_oe, so pin 0 is the MSB (0x80000000 for 32 pins).
- R3: Byte offsets are direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10 and edge-select 0x14. Direction, open-drain, data, mask and edge-select read back what was written. Any other offset reads zero and ignores writes.
- R4: A direction bit of 1 makes the pin an output and 0 makes it an input. An output pin drives pin_out from its data bit. pin_oe is 1 only for an output pin that is not open-drain, or for an open-drain output pin whose data bit is 0. Input pins never drive.
- R5: Reading the data register returns the data bit for output pins and the synchronized pin level for input pins. The level becomes visible two clock edges after pin_in changes.
- R6: An edge-select bit of 0 catches both rising and falling edges, and 1 catches falling edges only. A caught edge sets the pin's event bit on the third rising clock edge after pin_in changes.
- R7: Writing 1 to an event bit clears it. Writing 0 leaves it as it was.
- R8: If an edge is caught in the same cycle that a write of 1 clears that event bit, the bit stays set.
- R9: irq is high exactly when the bitwise AND of the event and mask registers is non-zero.
- R10: irq_pin gives the lowest-numbered pin among the pending unmasked events (the highest bit position). It is zero when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, committed on the rising edge |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for bus_addr (combinational) |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Value driven on each pin |
| pin_oe | output | NPINS | Per-pin driver enable |
| irq | output | 1 | Combined interrupt request |
| irq_pin | output | $clog2(NPINS) | Number of the highest-priority pending pin |

## Verification
The bench forces an edge to land in the same cycle as a write-one clear of that bit. A design that lets the clear win would lose the event, and the later event readback would show the bit as zero. It toggles a pin set for falling-only detection in both directions: a design with the select inverted or ignored would flag the rising edge or miss the falling one. Priority is checked with pins 10 and 20 pending together and again after pin 10 is cleared, so an encoder that scans from the LSB, or that reports bit positions rather than pin numbers, returns the wrong index. Open-drain pins holding a 1, and writes to an unmapped offset, check that nothing drives or changes when it should not.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   localparam logic [15:0] OFF_DIR = 16'h0000;
   localparam logic [15:0] OFF_ODN = 16'h0004;
   localparam logic [15:0] OFF_DAT = 16'h0008;
   localparam logic [15:0] OFF_EVT = 16'h000C;
   localparam logic [15:0] OFF_MSK = 16'h0010;
   localparam logic [15:0] OFF_EDG = 16'h0014;

   typedef enum logic [2:0] {
      SEL_DIR,
      SEL_ODN,
      SEL_DAT,
      SEL_EVT,
      SEL_MSK,
      SEL_EDG,
      SEL_NONE
   } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] lvl,
   output logic [W-1:0] lvl_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)      chain[s] <= '0;
         else if (s == 0) chain[s] <= raw;
         else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_prev <= '0;
      else        lvl_prev <= chain[STAGES-1];
   end

   assign lvl = chain[STAGES-1];
endmodule

// File: rtl/gpio_event_bank.sv
module gpio_event_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] lvl_prev,
   input  logic [W-1:0] fall_only,
   input  logic         clr_we,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] evt
);
   logic [W-1:0] hit;

   for (genvar g = 0; g < W; g++) begin : g_bit
      logic rise, fall;
      assign rise   = lvl[g] & ~lvl_prev[g];
      assign fall   = ~lvl[g] & lvl_prev[g];
      assign hit[g] = fall | (rise & ~fall_only[g]);

      always_ff @(posedge clk) begin
         if (!rst_n)                      evt[g] <= 1'b0;
         else if (hit[g])                 evt[g] <= 1'b1;
         else if (clr_we && clr_mask[g])  evt[g] <= 1'b0;
      end

      // R6 / R8: a caught edge always leaves the flag set
      a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
         hit[g] |=> evt[g]);
      // R7: write-one clears when no edge competes
      a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && clr_mask[g] && !hit[g]) |=> !evt[g]);
      // R7: without a clear the flag holds
      a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[g] && !(clr_we && clr_mask[g])) |=> evt[g]);
   end
endmodule

// File: rtl/gpio_prio_enc.sv
module gpio_prio_enc #(
   parameter int W           = 32,
   parameter bit PIN0_AT_MSB = 1'b1,
   localparam int IDX_W      = $clog2(W)
) (
   input  logic [W-1:0]     pend,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   logic [W-1:0] by_pin;

   if (PIN0_AT_MSB) begin : g_msb_first
      for (genvar n = 0; n < W; n++) begin : g_rev
         assign by_pin[n] = pend[W-1-n];
      end
   end else begin : g_lsb_first
      assign by_pin = pend;
   end

   always_comb begin
      idx = '0;
      for (int n = W-1; n >= 0; n--) begin
         if (by_pin[n]) idx = IDX_W'(n);
      end
   end

   assign any = |by_pin;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int NPINS     = 32,
   parameter int ADDR_W    = 8,
   parameter int SYNC_STG  = 2,
   localparam int IDX_W    = $clog2(NPINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic             bus_we,
   input  logic [NPINS-1:0] bus_wdata,
   output logic [NPINS-1:0] bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             irq,
   output logic [IDX_W-1:0] irq_pin
);
   if (NPINS < 2 || NPINS > 32) begin : g_bad_npins
      $error("gpio_edge_ctrl: NPINS must lie in 2..32");
   end
   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
      $error("gpio_edge_ctrl: ADDR_W must lie in 5..16");
   end

   reg_sel_e         sel;
   logic [NPINS-1:0] dir_q, odn_q, dat_q, msk_q, edg_q;
   logic [NPINS-1:0] evt, lvl, lvl_prev, pend;

   always_comb begin
      case (16'(bus_addr))
         OFF_DIR: sel = SEL_DIR;
         OFF_ODN: sel = SEL_ODN;
         OFF_DAT: sel = SEL_DAT;
         OFF_EVT: sel = SEL_EVT;
         OFF_MSK: sel = SEL_MSK;
         OFF_EDG: sel = SEL_EDG;
         default: sel = SEL_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         odn_q <= '0;
         dat_q <= '0;
         msk_q <= '0;
         edg_q <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_DIR: dir_q <= bus_wdata;
            SEL_ODN: odn_q <= bus_wdata;
            SEL_DAT: dat_q <= bus_wdata;
            SEL_MSK: msk_q <= bus_wdata;
            SEL_EDG: edg_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   gpio_pin_sync #(.W(NPINS), .STAGES(SYNC_STG)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (pin_in),
      .lvl      (lvl),
      .lvl_prev (lvl_prev)
   );

   gpio_event_bank #(.W(NPINS)) u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl       (lvl),
      .lvl_prev  (lvl_prev),
      .fall_only (edg_q),
      .clr_we    (bus_we && (sel == SEL_EVT)),
      .clr_mask  (bus_wdata),
      .evt       (evt)
   );

   assign pend = evt & msk_q;

   gpio_prio_enc #(.W(NPINS), .PIN0_AT_MSB(1'b1)) u_prio (
      .pend (pend),
      .any  (irq),
      .idx  (irq_pin)
   );

   always_comb begin
      case (sel)
         SEL_DIR: bus_rdata = dir_q;
         SEL_ODN: bus_rdata = odn_q;
         SEL_DAT: bus_rdata = (dat_q & dir_q) | (lvl & ~dir_q);
         SEL_EVT: bus_rdata = evt;
         SEL_MSK: bus_rdata = msk_q;
         SEL_EDG: bus_rdata = edg_q;
         default: bus_rdata = '0;
      endcase
   end

   assign pin_out = dat_q;
   assign pin_oe  = dir_q & ~(odn_q & dat_q);

   // R3: a direction write lands on the next cycle
   a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_DIR) |=> dir_q == $past(bus_wdata));
   // R3: a mask write lands on the next cycle
   a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_MSK) |=> msk_q == $past(bus_wdata));
   // R9: encoder request agrees with the event and mask registers
   a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(evt & msk_q));
   // R10: the reported pin really is pending
   a_r10_pick_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pend[NPINS-1-int'(irq_pin)]);
   // R10: nothing pending means index zero
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> irq_pin == '0);
endmodule

// File: tb/gpio_edge_ctrl_test.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_test;
   localparam int N = 32;

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq;
   logic [4:0]  irq_pin;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   item_t sb[$];

   always #2 clk = ~clk;

   gpio_edge_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .irq_pin(irq_pin)
   );

   function automatic logic [31:0] pb(int n);
      return 32'h8000_0000 >> n;
   endfunction

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      step(1);
      bus_we = 1'b0;
   endtask

   // sel: 0 read, 1 irq, 2 irq_pin, 3 pin_oe, 4 pin_out & pin_oe
   task automatic expect_item(int sel, logic [7:0] a, logic [31:0] e, string r);
      item_t it;
      bus_addr = a;
      it.sel = sel; it.exp = e; it.req = r;
      sb.push_back(it);
      step(1);
   endtask

   // monitor: pops at the falling edge, away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.sel)
               0:       act = bus_rdata;
               1:       act = {31'd0, irq};
               2:       act = {27'd0, irq_pin};
               3:       act = pin_oe;
               default: act = pin_out & pin_oe;
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      for (int a = 0; a <= 'h14; a += 4) expect_item(0, 8'(a), 32'h0, "R1 reg reset");
      expect_item(1, 8'h00, 32'h0, "R1 irq reset");
      expect_item(3, 8'h00, 32'h0, "R1 oe reset");

      // R3 / R4 / R2 outputs
      wr(8'h00, pb(0) | pb(5));
      wr(8'h08, pb(0));
      expect_item(0, 8'h00, pb(0) | pb(5), "R3 dir readback");
      expect_item(3, 8'h00, pb(0) | pb(5), "R4 oe push-pull");
      expect_item(4, 8'h00, 32'h8000_0000, "R2 pin0 is MSB");
      wr(8'h04, pb(0));
      expect_item(0, 8'h04, pb(0), "R3 open-drain readback");
      expect_item(3, 8'h00, pb(5), "R4 open-drain high released");

      // R3 unmapped offset
      wr(8'h18, 32'hFFFF_FFFF);
      expect_item(0, 8'h18, 32'h0, "R3 unmapped reads zero");
      expect_item(0, 8'h00, pb(0) | pb(5), "R3 unmapped write ignored");

      // R5 data readback mixes outputs and synced inputs
      pin_in = pb(10) | pb(5);
      step(2);
      expect_item(0, 8'h08, pb(0) | pb(10), "R5 data readback");
      step(1);
      // R6 both-edge default: events for pins 5 and 10
      expect_item(0, 8'h0C, pb(10) | pb(5), "R6 rising caught");
      expect_item(1, 8'h00, 32'h0, "R9 masked no irq");

      // R7 write-one-to-clear
      wr(8'h0C, pb(5));
      expect_item(0, 8'h0C, pb(10), "R7 w1c clears");
      wr(8'h0C, 32'h0);
      expect_item(0, 8'h0C, pb(10), "R7 write zero keeps");

      // R9 / R10
      wr(8'h10, pb(10) | pb(20));
      expect_item(1, 8'h00, 32'h1, "R9 irq raised");
      expect_item(2, 8'h00, 32'd10, "R10 pin10 reported");

      // R6 falling-only
      wr(8'h14, pb(20));
      pin_in = pb(10) | pb(5) | pb(20);
      step(4);
      expect_item(0, 8'h0C, pb(10), "R6 falling-only ignores rise");
      pin_in = pb(10) | pb(5);
      step(4);
      expect_item(0, 8'h0C, pb(10) | pb(20), "R6 falling-only catches fall");
      expect_item(2, 8'h00, 32'd10, "R10 lower pin wins");
      wr(8'h0C, pb(10));
      expect_item(2, 8'h00, 32'd20, "R10 next pin after clear");
      pin_in = pb(5);
      step(4);
      expect_item(0, 8'h0C, pb(10) | pb(20), "R6 both-edge catches fall");
      expect_item(2, 8'h00, 32'd10, "R10 pin10 back on top");

      // R8 edge and clear in the same cycle
      wr(8'h0C, 32'hFFFF_FFFF);
      expect_item(0, 8'h0C, 32'h0, "R7 clear all");
      pin_in = pb(5) | pb(3);
      step(2);
      wr(8'h0C, pb(3));
      expect_item(0, 8'h0C, pb(3), "R8 edge beats clear");

      // R9 / R10 with nothing unmasked
      wr(8'h10, 32'h0);
      expect_item(1, 8'h00, 32'h0, "R9 irq drops");
      expect_item(2, 8'h00, 32'h0, "R10 idle index zero");

      step(2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule